// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a 128-byte serial memory that sits as a slave on a two-wire bus. A fast system clock samples the bus clock and data lines. The block finds the bus framing events, takes in the device byte and compares it with its fixed type code and its three strap pins. It then runs the transaction the master asks for, and drives only a pull-low enable for the open-drain data line.

On the memory side there is a simple synchronous port: an address, a one-cycle write strobe with its data, and read data that appears one system clock after the address. A busy flag from the write-cycle controller makes the block refuse its address, so the master can poll until an earlier write is finished. Supported transactions are byte and multi-byte writes, current-address reads, random reads (a write header followed by a repeated start) and sequential reads that a NACK ends.

Top module: `eep_slave_engine`

## Requirements
- R1: A start (data falling while clock is high) puts the engine into device-byte reception. A stop (data rising while clock is high) returns it to idle. Data changes while the clock is low are treated as bits.
- R2: With no start since reset or since the last stop, and after a device byte that does not match, the engine never pulls the data line until the next start.
- R3: The device byte is sent MSB first as type[3:0], strap[2:0], direction. The engine acknowledges it, by pulling data low through the ninth clock, only when type equals 4'b1010 and the middle three bits equal strap_i.
- R4: A direction bit of 0 selects a write. The next byte is a word address, of which only bits [6:0] are kept. The engine acknowledges it and every following data byte. Consecutive data bytes are stored at consecutive addresses, and the address wraps from 127 to 0.
- R5: While busy_i is high, a matching device byte is not acknowledged.
- R6: A direction bit of 1 selects a read. The engine shifts out 8 bits, MSB first, and releases data for the ninth clock. A master acknowledge (low) there brings the next byte. A NACK (high) silences the engine until the next start or stop.
- R7: A write header with a word address, followed by a repeated start and a read header, returns data from that word address.
- R8: A read that has no word address returns data from the address just after the last byte read or written.
- R9: The read address advances over all 7 bits, so a sequential read of address 127 is followed by address 0.
- R10: A start or a stop in the middle of a byte abandons that byte. A later complete transaction works normally.
- R11: The pull-low enable changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| strap_i | input | 3 | Device select strap pins |
| busy_i | input | 1 | Write-cycle controller busy flag |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| mem_addr_o | output | AW | Memory array address |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid one clock after mem_addr_o |

## Verification
The checks on when the pull enable may toggle take for granted that every bus clock low and high phase lasts longer than the synchronizer depth plus a few system clocks. They also assume the master moves data only in the middle of the low phase. The bench master holds every phase for at least 8 system clocks and changes data at least 8 clocks after a clock edge. It never creates a start or stop while the engine is pulling the line, so the framing seen through the synchronizer always matches the intended bus sequence.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_HOLD
  } eep_state_e;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, lvl, lvl_q;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '1;
    else         lvl_q <= lvl;
  end

  assign scl_lvl_o  = lvl[1];
  assign sda_lvl_o  = lvl[0];
  assign scl_rise_o = lvl[1] & ~lvl_q[1];
  assign scl_fall_o = ~lvl[1] & lvl_q[1];
  // framing only counts when clock was high on both samples
  assign start_o    = lvl[1] & lvl_q[1] & lvl_q[0] & ~lvl[0];
  assign stop_o     = lvl[1] & lvl_q[1] & ~lvl_q[0] & lvl[0];
endmodule

// File: rtl/eep_dev_match.sv
module eep_dev_match #(
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic [7:0] dev_byte_i,
  input  logic [2:0] strap_i,
  output logic       hit_o
);
  assign hit_o = (dev_byte_i[7:4] == DEV_TYPE) && (dev_byte_i[3:1] == strap_i);
endmodule

// File: rtl/eep_xact_fsm.sv
module eep_xact_fsm
  import eep_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              dev_hit_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              pull_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic [BYTE_W-1:0] mem_wdata_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  eep_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, wdata_q;
  logic [BYTE_W-2:0] tx_q;
  logic [AW-1:0]     ptr_q;
  logic              pull_q, we_q, rw_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      pull_q  <= 1'b0;
      we_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      // pointer steps one clock after the strobe so the array sees the old address
      if (we_q) begin
        we_q  <= 1'b0;
        ptr_q <= ptr_q + AW'(1);
      end
      if (start_i) begin
        st_q   <= ST_DEV;
        cnt_q  <= '0;
        pull_q <= 1'b0;
      end else if (stop_i) begin
        st_q   <= ST_IDLE;
        cnt_q  <= '0;
        pull_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise_i && cnt_q < LAST_BIT) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_lvl_i};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall_i && cnt_q == LAST_BIT) begin
              cnt_q <= '0;
              if (st_q == ST_DEV) begin
                if (dev_hit_i && !busy_i) begin
                  pull_q <= 1'b1;
                  rw_q   <= rx_q[0];
                  st_q   <= ST_DEV_ACK;
                end else begin
                  st_q <= ST_HOLD;
                end
              end else if (st_q == ST_WADDR) begin
                ptr_q  <= rx_q[AW-1:0];
                pull_q <= 1'b1;
                st_q   <= ST_WADDR_ACK;
              end else begin
                we_q    <= 1'b1;
                wdata_q <= rx_q;
                pull_q  <= 1'b1;
                st_q    <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (st_q == ST_DEV_ACK && rw_q) begin
                tx_q   <= mem_rdata_i[BYTE_W-2:0];
                pull_q <= ~mem_rdata_i[BYTE_W-1];
                st_q   <= ST_RDATA;
              end else begin
                pull_q <= 1'b0;
                st_q   <= (st_q == ST_DEV_ACK) ? ST_WADDR : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall_i) begin
              if (cnt_q == LAST_TX) begin
                pull_q <= 1'b0;
                ptr_q  <= ptr_q + AW'(1);
                st_q   <= ST_RACK;
              end else begin
                pull_q <= ~tx_q[BYTE_W-2];
                tx_q   <= {tx_q[BYTE_W-3:0], 1'b0};
                cnt_q  <= cnt_q + CNT_W'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_lvl_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                tx_q   <= mem_rdata_i[BYTE_W-2:0];
                pull_q <= ~mem_rdata_i[BYTE_W-1];
                cnt_q  <= '0;
                st_q   <= ST_RDATA;
              end else begin
                st_q <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_byte_o   = rx_q;
  assign pull_o      = pull_q;
  assign mem_addr_o  = ptr_q;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wdata_q;

  a_r2_quiet_when_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE || st_q == ST_HOLD) |-> !pull_o);

  a_r11_pull_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pull_o) |-> !scl_lvl_i);

  a_r4_single_write_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  a_r4_strobe_then_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (mem_addr_o != $past(mem_addr_o)));

  a_r6_release_for_master_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RACK) |-> !pull_o);

  a_r10_bit_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_BIT);

  a_r1_start_enters_dev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_q == ST_DEV && cnt_q == '0));
endmodule

// File: rtl/eep_slave_engine.sv
module eep_slave_engine #(
  parameter int         AW          = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic          busy_i,
  output logic          sda_pull_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det, dev_hit;
  logic [7:0] rx_byte;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_lvl_o  (scl_lvl),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  eep_dev_match #(.DEV_TYPE(DEV_TYPE)) u_match (
    .dev_byte_i (rx_byte),
    .strap_i    (strap_i),
    .hit_o      (dev_hit)
  );

  eep_xact_fsm #(.AW(AW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_lvl_i   (scl_lvl),
    .sda_lvl_i   (sda_lvl),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .dev_hit_i   (dev_hit),
    .busy_i      (busy_i),
    .mem_rdata_i (mem_rdata_i),
    .rx_byte_o   (rx_byte),
    .pull_o      (sda_pull_o),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o)
  );
endmodule

// File: tb/sim_eep_slave_engine.sv
`timescale 1ns/1ps
module sim_eep_slave_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_pull, mem_we;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_bus = sda_m & ~sda_pull;

  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  int n_chk = 0, n_fail = 0;
  int ref_mem[128];
  int ref_ptr = 0;
  logic [7:0] arr[128];
  logic prev_pull = 1'b0;
  int scl_hi_run = 0;

  always #2.5 clk = ~clk;

  eep_slave_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .busy_i(busy), .sda_pull_o(sda_pull),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  initial for (int i = 0; i < 128; i++) begin
    arr[i] = 8'(i ^ 8'h55);
    ref_mem[i] = (i ^ 8'h55) & 8'hFF;
  end

  always @(posedge clk) begin
    if (mem_we) arr[mem_addr] <= mem_wdata;
    mem_rdata <= arr[mem_addr];
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R11: per-clock comparison, pull enable must hold while bus clock is high
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_m) scl_hi_run++; else scl_hi_run = 0;
      if (scl_hi_run > 4) chk("R11 pull stable while clock high", sda_pull, prev_pull);
      prev_pull = sda_pull;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_clk(8); scl_m = 1'b1; wait_clk(20); scl_m = 1'b0; wait_clk(12);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_clk(8); scl_m = 1'b1; wait_clk(10); b = sda_bus;
    wait_clk(10); scl_m = 1'b0; wait_clk(12);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(8); scl_m = 1'b1; wait_clk(10);
    sda_m = 1'b0; wait_clk(10); scl_m = 1'b0; wait_clk(12);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(8); scl_m = 1'b1; wait_clk(10); sda_m = 1'b1; wait_clk(20);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~mack);
  endtask

  task automatic mem_write(input logic [7:0] wa, input int n, input logic [7:0] d[4]);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack); chk("R3 write header ack", ack, 1);
    send_byte(wa, ack);    chk("R4 word address ack", ack, 1);
    ref_ptr = wa & 8'h7F;
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], ack); chk("R4 data ack", ack, 1);
      ref_mem[ref_ptr] = d[k];
      ref_ptr = (ref_ptr + 1) % 128;
    end
    bus_stop();
  endtask

  task automatic read_body(input int n, input string req);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, v);
      chk(req, v, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % 128;
    end
  endtask

  task automatic rand_read(input logic [7:0] wa, input int n, input string req);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack); chk("R7 dummy header ack", ack, 1);
    send_byte(wa, ack);    chk("R7 word address ack", ack, 1);
    bus_start();
    send_byte(DEV_R, ack); chk("R7 read header ack", ack, 1);
    ref_ptr = wa & 8'h7F;
    read_body(n, req);
    bus_stop();
  endtask

  task automatic cur_read(input int n, input string req);
    logic ack;
    bus_start();
    send_byte(DEV_R, ack); chk("R8 read header ack", ack, 1);
    read_body(n, req);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R2 reset pull released", sda_pull, 0);
    chk("R4 reset no write strobe", mem_we, 0);

    // R2: a full header clocked in with no start before it
    scl_m = 1'b0; wait_clk(12);
    send_byte(DEV_W, ack); chk("R2 no ack before start", ack, 0);
    bus_stop();

    // R1, R3, R4: byte write, then multi-byte write with MSB of word address set
    mem_write(8'h10, 1, '{8'h5C, 8'h00, 8'h00, 8'h00});
    mem_write(8'h91, 2, '{8'h3E, 8'hC4, 8'h00, 8'h00});

    // R7: random read
    rand_read(8'h10, 1, "R7 random read data");
    // R8: current address after read of 0x10
    cur_read(1, "R8 current read after read");
    cur_read(1, "R8 current read next");

    // R3, R2: mismatched strap and mismatched type, following bytes ignored
    bus_start();
    send_byte(8'hA2, ack); chk("R3 wrong strap nack", ack, 0);
    send_byte(8'h10, ack); chk("R2 ignored after mismatch", ack, 0);
    send_byte(8'hFF, ack); chk("R2 ignored data", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hBA, ack); chk("R3 wrong type nack", ack, 0);
    bus_stop();
    rand_read(8'h10, 1, "R2 memory untouched by ignored bytes");

    // R5: busy refuses the header
    busy = 1'b1;
    bus_start();
    send_byte(DEV_W, ack); chk("R5 busy nack", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(DEV_W, ack); chk("R5 ack after busy drops", ack, 1);
    bus_stop();

    // R4/R9: write across the top of the address space
    mem_write(8'h7F, 2, '{8'h81, 8'h42, 8'h00, 8'h00});
    // R9, R6: sequential read 0x7E, 0x7F, 0x00 then NACK
    rand_read(8'h7E, 3, "R9 sequential read wrap");
    chk("R9 wrap reached address 0", ref_mem[0], 8'h42);
    // R6: after NACK the engine is silent for a further byte
    bus_start();
    send_byte(DEV_R, ack); chk("R6 read header ack", ack, 1);
    recv_byte(1'b0, v); chk("R6 data before nack", v, ref_mem[ref_ptr]);
    ref_ptr = (ref_ptr + 1) % 128;
    recv_byte(1'b0, v); chk("R6 silent after nack", v, 8'hFF);
    bus_stop();
    cur_read(1, "R8 current read after nack");

    // R10: stop in mid-byte, then start in mid-byte, then a good write
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    chk("R10 idle after mid-byte stop", sda_pull, 0);
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte(DEV_W, ack); chk("R10 header after mid-byte start", ack, 1);
    send_byte(8'h20, ack); chk("R10 word ack", ack, 1);
    send_byte(8'h99, ack); chk("R10 data ack", ack, 1);
    bus_stop();
    ref_mem[32] = 8'h99;
    rand_read(8'h20, 1, "R10 data after aborted bytes");

    wait_clk(20);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule